// File: doc/BRIEF.md
# Pattern-Monitor Bit and Error Tally

This block tallies the bits and bit errors reported by a pseudo-random or fixed-pattern checker across an interval that software defines by pulsing an update input. It runs two counters during the interval: one for received bits and one for bit errors. When the update pulse arrives, both counts are copied into holding registers and the counters start again. The holding registers drive the outputs, so a reader always sees the totals of the interval that has just closed and never a value that is still changing.

While the pattern checker reports that it has lost lock, its bit and error strobes are not counted. This keeps a realignment burst from being reported as errors. Each counter stops at its all-ones value instead of wrapping to zero. A flag output shows whether the reported error total is nonzero. The pattern checker and the register access path sit outside this block.

Top module: `bert_pm_counters`

## Requirements
- R1: After a synchronous reset, the reported error total, the reported bit total and the nonzero flag are all 0.
- R2: The reported bit total equals the number of clock cycles in the previous interval with bit_vld=1 and oos=0. It becomes visible on the clock edge that samples upd=1.
- R3: The reported error total equals the number of cycles in the previous interval with bit_vld=1, bit_err=1 and oos=0.
- R4: Cycles with oos=1 add nothing to either total.
- R5: err_nz is 1 exactly when the reported error total is greater than 0.
- R6: A bit or error presented on the same cycle as upd=1 is counted in the new interval and not in the totals being reported.
- R7: Each running counter stops at its all-ones value (ERR_W or BIT_W bits) instead of wrapping. The next upd reports that value and restarts the count.
- R8: bit_err=1 with bit_vld=0 is not counted.
- R9: Between update pulses, the reported totals and err_nz do not change, whatever the strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | One received bit this cycle |
| bit_err | input | 1 | The received bit mismatched the pattern (only meaningful with bit_vld) |
| oos | input | 1 | Checker is out of lock; suspends counting |
| upd | input | 1 | Closes the interval: snapshot and restart |
| err_cnt | output | ERR_W (24) | Error total of the previous interval |
| bit_cnt | output | BIT_W (32) | Bit total of the previous interval |
| err_nz | output | 1 | err_cnt is greater than 0 |

## Verification
Saturation is the hardest case to reach from the ports. A 32-bit bit counter cannot be filled in any reasonable run time. The bench therefore builds a second copy of the block with 3-bit and 4-bit counters, drives it for more cycles than those widths can hold, and then checks that the next interval starts again from zero. The other hard case is the boundary cycle where an update coincides with a bit strobe. The bench produces it by raising upd together with bit_vld and bit_err, then checks the old and new interval totals one after the other.

// File: rtl/bert_pm_pkg.sv
package bert_pm_pkg;
  localparam int DEF_ERR_W = 24;
  localparam int DEF_BIT_W = 32;
endpackage

// File: rtl/bert_pm_sat_cnt.sv
module bert_pm_sat_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (clr)
      cnt <= inc ? W'(1) : '0;   // boundary event belongs to new interval
    else if (inc && cnt != TOP)
      cnt <= cnt + W'(1);
  end

  // R7: a full counter stays full until cleared
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == TOP) |=> (cnt == TOP));
endmodule

// File: rtl/bert_pm_snapshot.sv
module bert_pm_snapshot #(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [ERR_W-1:0] run_err,
  input  logic [BIT_W-1:0] run_bit,
  output logic [ERR_W-1:0] err_cnt,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             err_nz
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt <= '0;
      bit_cnt <= '0;
      err_nz  <= 1'b0;
    end else if (load) begin
      err_cnt <= run_err;
      bit_cnt <= run_bit;
      err_nz  <= |run_err;
    end
  end

  // R9: snapshot only moves on load
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(err_cnt) && $stable(bit_cnt) && $stable(err_nz)));
  // R5: flag agrees with reported total
  a_r5_flag_match: assert property (@(posedge clk) disable iff (rst)
    err_nz == (err_cnt != '0));
endmodule

// File: rtl/bert_pm_counters.sv
module bert_pm_counters
  import bert_pm_pkg::*;
#(
  parameter int ERR_W = DEF_ERR_W,
  parameter int BIT_W = DEF_BIT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_vld,
  input  logic             bit_err,
  input  logic             oos,
  input  logic             upd,
  output logic [ERR_W-1:0] err_cnt,
  output logic [BIT_W-1:0] bit_cnt,
  output logic             err_nz
);
  logic             take_bit, take_err;
  logic [ERR_W-1:0] run_err;
  logic [BIT_W-1:0] run_bit;

  // R4, R8: only in-lock, valid bits count
  assign take_bit = bit_vld & ~oos;
  assign take_err = take_bit & bit_err;

  bert_pm_sat_cnt #(.W(BIT_W)) u_bits (
    .clk(clk), .rst(rst), .clr(upd), .inc(take_bit), .cnt(run_bit));

  bert_pm_sat_cnt #(.W(ERR_W)) u_errs (
    .clk(clk), .rst(rst), .clr(upd), .inc(take_err), .cnt(run_err));

  bert_pm_snapshot #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_snap (
    .clk(clk), .rst(rst), .load(upd), .run_err(run_err), .run_bit(run_bit),
    .err_cnt(err_cnt), .bit_cnt(bit_cnt), .err_nz(err_nz));

  // R1: reset clears reported values
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> (err_cnt == '0 && bit_cnt == '0 && !err_nz));
  // R4: out-of-lock cycles leave running counts untouched
  a_r4_oos_frozen: assert property (@(posedge clk) disable iff (rst)
    (oos && !upd) |=> ($stable(run_bit) && $stable(run_err)));
  // R3: errors never outnumber bits
  a_r3_err_le_bits: assert property (@(posedge clk) disable iff (rst)
    BIT_W'(run_err) <= run_bit);
endmodule

// File: tb/sim_bert_pm_counters.sv
`timescale 1ns/1ps
module sim_bert_pm_counters;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_vld = 1'b0, bit_err = 1'b0, oos = 1'b0, upd = 1'b0;
  logic [23:0] err_cnt;
  logic [31:0] bit_cnt;
  logic        err_nz;
  logic [2:0]  s_err;
  logic [3:0]  s_bit;
  logic        s_nz;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bert_pm_counters u0 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err), .oos(oos),
    .upd(upd), .err_cnt(err_cnt), .bit_cnt(bit_cnt), .err_nz(err_nz));

  bert_pm_counters #(.ERR_W(3), .BIT_W(4)) u1 (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_err(bit_err), .oos(oos),
    .upd(upd), .err_cnt(s_err), .bit_cnt(s_bit), .err_nz(s_nz));

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle; returns at the following negedge
  task automatic cyc(logic v, logic e, logic o, logic u);
    bit_vld = v; bit_err = e; oos = o; upd = u;
    @(negedge clk);
    bit_vld = 0; bit_err = 0; oos = 0; upd = 0;
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R1 err", err_cnt, 0);
    chk("R1 bits", bit_cnt, 0);
    chk("R1 nz", err_nz, 0);
    rst = 0;
    cyc(0, 0, 0, 1);
  endtask

  task automatic t_basic;
    for (int i = 0; i < 10; i++) cyc(1, i < 3, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R2 bits", bit_cnt, 10);
    chk("R3 errs", err_cnt, 3);
    chk("R5 nz set", err_nz, 1);
  endtask

  task automatic t_oos;
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(1, 1, 1, 0);
    for (int i = 0; i < 2; i++) cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R4 bits", bit_cnt, 7);
    chk("R4 errs", err_cnt, 2);
  endtask

  task automatic t_err_novld;
    for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R8 bits", bit_cnt, 3);
    chk("R8 errs", err_cnt, 0);
    chk("R5 nz clear", err_nz, 0);
  endtask

  task automatic t_boundary;
    for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 1);
    chk("R6 old bits", bit_cnt, 4);
    chk("R6 old errs", err_cnt, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R6 new bits", bit_cnt, 3);
    chk("R6 new errs", err_cnt, 1);
  endtask

  task automatic t_hold;
    cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0);
    chk("R9 bits held", bit_cnt, 1);
    chk("R9 errs held", err_cnt, 1);
    chk("R9 nz held", err_nz, 1);
    cyc(0, 0, 0, 1);
    chk("R9 then loads", bit_cnt, 20);
  endtask

  task automatic t_sat;
    cyc(0, 0, 0, 1);
    for (int i = 0; i < 25; i++) cyc(1, 1, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R7 bits sat", s_bit, 15);
    chk("R7 errs sat", s_err, 7);
    chk("R7 wide unsat", bit_cnt, 25);
    cyc(1, 1, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 1);
    chk("R7 restart bits", s_bit, 2);
    chk("R7 restart errs", s_err, 1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_oos();
    t_err_novld();
    t_boundary();
    t_hold();
    t_sat();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule